// File: doc/BRIEF.md
# Streaming CCK Codeword Correlator

This block scores each received 8-chip complementary-code-keying codeword against all 64 phase hypotheses of the higher 802.11b rates. It reports the hypothesis with the strongest match. Complex chips arrive one at a time with a qualifying strobe, and no block of chips is gathered first. Each arriving odd chip is merged with the even chip held before it. Each later stage merges two results of the stage before it once the second one exists. Every merge rotates the earlier operand by a quarter-turn multiple and adds it to the later one. Such a rotation is only a swap and a negation of the real and imaginary parts, so the block has no multipliers.

The three merge stages run as a pipeline, so codewords may follow each other with no idle cycles between them. After the third stage, all 64 correlations sit in a register bank. A magnitude search over that bank gives the index and magnitude of the strongest hypothesis as a one-cycle result.

Top module: `cck_correlator`

## Requirements
- R1: Only a cycle with `chip_valid_i` high advances the chip position within a codeword. The eighth accepted chip completes the word. Idle cycles of any length between chips do not change the result.
- R2: Chips are numbered k = 0..7 in arrival order, and k has bits b2 b1 b0. Hypothesis (d2,d3,d4) scores Z = Σ s_k·x_k·(−j)^e_k. Here s_k = −1 for k = 3 and k = 6 and +1 otherwise, and e_k = d2·(1−b0) + d3·(1−b1) + d4·(1−b2), taken mod 4.
- R3: The result index packs the hypothesis as bits [1:0] = d2, [3:2] = d3 and [5:4] = d4.
- R4: `result_mag_o` is |Re Z| + |Im Z| of the winning hypothesis, and no other hypothesis has a larger value.
- R5: When several hypotheses share the largest magnitude, the lowest index is reported.
- R6: `result_valid_o` rises exactly three clock edges after the edge that captures chip 7, stays high for one cycle, and is never raised otherwise.
- R7: Codewords presented back to back, with chip 0 of the next word in the cycle after chip 7, each give their own correct result.
- R8: Full-scale chips, including −128 on both parts, give exact results with no wrap-around, and the magnitude never exceeds 2048.
- R9: The active-low asynchronous reset clears `result_valid_o`, `result_idx_o` and `result_mag_o` to zero and returns the chip position to chip 0, so a partly received word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_valid_i | input | 1 | Qualifies the chip on the data inputs |
| chip_re_i | input | CHIP_W | Signed real part of the chip |
| chip_im_i | input | CHIP_W | Signed imaginary part of the chip |
| result_valid_o | output | 1 | One-cycle strobe marking a finished codeword |
| result_idx_o | output | 6 | Winning hypothesis index {d4,d3,d2} |
| result_mag_o | output | CHIP_W+5 | Magnitude of the winning correlation |

## Verification
A result is due three edges after the edge that captures the eighth chip of its word. The stages add one edge each: pair merge on the capture edge, then quad merge, final merge, and peak register. When the driver presents a last chip, it stamps the expected item with the current cycle count plus four. The monitor pops items only on cycles where `result_valid_o` is high. It compares the stamp with its own cycle count, so an early, late, missing or extra strobe is reported along with any wrong index or magnitude.

// File: rtl/cck_pkg.sv
package cck_pkg;
  localparam int unsigned NUM_STAGES     = 3;
  localparam int unsigned CHIPS_PER_WORD = 2 ** NUM_STAGES;
  localparam int unsigned NUM_HYP        = 4 ** NUM_STAGES;
  localparam int unsigned IDX_W          = 2 * NUM_STAGES;
  localparam int unsigned POS_W          = NUM_STAGES;

  // chips 3 and 6 carry an extra half-turn in the code
  function automatic logic chip_inverted(input logic [POS_W-1:0] pos);
    return (pos == POS_W'(3)) || (pos == POS_W'(6));
  endfunction
endpackage

// File: rtl/cck_bfly_stage.sv
module cck_bfly_stage #(
  parameter int unsigned IN_W = 9,
  parameter int unsigned N_IN = 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             valid_i,
  input  logic [cck_pkg::POS_W-1:0]        pos_i,
  input  logic signed [IN_W-1:0]           re_i [N_IN],
  input  logic signed [IN_W-1:0]           im_i [N_IN],
  output logic                             valid_o,
  output logic [cck_pkg::POS_W-1:0]        pos_o,
  output logic signed [IN_W:0]             re_o [4*N_IN],
  output logic signed [IN_W:0]             im_o [4*N_IN]
);
  localparam int unsigned OUT_W = IN_W + 1;
  localparam int unsigned N_OUT = 4 * N_IN;

  logic signed [IN_W-1:0]  hold_re [N_IN];
  logic signed [IN_W-1:0]  hold_im [N_IN];
  logic signed [OUT_W-1:0] sum_re  [N_OUT];
  logic signed [OUT_W-1:0] sum_im  [N_OUT];
  logic take_first, take_second;

  assign take_first  = valid_i && !pos_i[0];
  assign take_second = valid_i &&  pos_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_re <= '{default: '0};
      hold_im <= '{default: '0};
    end else if (take_first) begin
      hold_re <= re_i;
      hold_im <= im_i;
    end
  end

  // lane d*N_IN+i : earlier operand rotated by (-j)^d plus later operand
  for (genvar d = 0; d < 4; d++) begin : g_rot
    for (genvar i = 0; i < N_IN; i++) begin : g_lane
      logic signed [OUT_W-1:0] hr, hi, cr, ci, rr, ri;
      assign hr = OUT_W'(hold_re[i]);
      assign hi = OUT_W'(hold_im[i]);
      assign cr = OUT_W'(re_i[i]);
      assign ci = OUT_W'(im_i[i]);
      if (d == 0) begin : g_q0
        assign rr = hr;
        assign ri = hi;
      end else if (d == 1) begin : g_q1
        assign rr = hi;
        assign ri = -hr;
      end else if (d == 2) begin : g_q2
        assign rr = -hr;
        assign ri = -hi;
      end else begin : g_q3
        assign rr = -hi;
        assign ri = hr;
      end
      assign sum_re[d*N_IN+i] = rr + cr;
      assign sum_im[d*N_IN+i] = ri + ci;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pos_o   <= '0;
    end else begin
      valid_o <= take_second;
      if (take_second) pos_o <= pos_i >> 1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (take_second) begin
      re_o <= sum_re;
      im_o <= sum_im;
    end
  end
endmodule

// File: rtl/cck_peak_pick.sv
module cck_peak_pick #(
  parameter int unsigned W     = 12,
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [W-1:0]  re_i [N],
  input  logic signed [W-1:0]  im_i [N],
  output logic                 valid_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [W:0]           mag_o
);
  localparam int unsigned MAG_W = W + 1;

  logic [MAG_W-1:0] mag [N];
  logic [MAG_W-1:0] best_mag;
  logic [IDX_W-1:0] best_idx;

  for (genvar k = 0; k < N; k++) begin : g_mag
    logic signed [MAG_W-1:0] er, ei;
    logic [MAG_W-1:0] ar, ai;
    assign er = MAG_W'(re_i[k]);
    assign ei = MAG_W'(im_i[k]);
    assign ar = (er < 0) ? MAG_W'(-er) : MAG_W'(er);
    assign ai = (ei < 0) ? MAG_W'(-ei) : MAG_W'(ei);
    assign mag[k] = ar + ai;
  end

  // strict compare keeps the earliest index on ties
  always_comb begin
    best_mag = mag[0];
    best_idx = '0;
    for (int k = 1; k < N; k++) begin
      if (mag[k] > best_mag) begin
        best_mag = mag[k];
        best_idx = IDX_W'(k);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
      mag_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        idx_o <= best_idx;
        mag_o <= best_mag;
      end
    end
  end
endmodule

// File: rtl/cck_correlator.sv
module cck_correlator #(
  parameter int unsigned CHIP_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     chip_valid_i,
  input  logic signed [CHIP_W-1:0] chip_re_i,
  input  logic signed [CHIP_W-1:0] chip_im_i,
  output logic                     result_valid_o,
  output logic [cck_pkg::IDX_W-1:0] result_idx_o,
  output logic [CHIP_W+4:0]        result_mag_o
);
  import cck_pkg::*;

  localparam int unsigned W0 = CHIP_W + 1;  // after sign fold
  localparam int unsigned W1 = W0 + 1;
  localparam int unsigned W2 = W1 + 1;
  localparam int unsigned W3 = W2 + 1;

  logic [POS_W-1:0] chip_pos;
  logic             inv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           chip_pos <= '0;
    else if (chip_valid_i) chip_pos <= chip_pos + POS_W'(1);
  end

  assign inv = chip_inverted(chip_pos);

  logic signed [W0-1:0] s0_re [1];
  logic signed [W0-1:0] s0_im [1];
  assign s0_re[0] = inv ? -W0'(chip_re_i) : W0'(chip_re_i);
  assign s0_im[0] = inv ? -W0'(chip_im_i) : W0'(chip_im_i);

  logic                 s1_valid, s2_valid, s3_valid;
  logic [POS_W-1:0]     s1_pos, s2_pos, s3_pos;
  logic signed [W1-1:0] s1_re [4];
  logic signed [W1-1:0] s1_im [4];
  logic signed [W2-1:0] s2_re [16];
  logic signed [W2-1:0] s2_im [16];
  logic signed [W3-1:0] s3_re [NUM_HYP];
  logic signed [W3-1:0] s3_im [NUM_HYP];

  cck_bfly_stage #(.IN_W(W0), .N_IN(1)) u_pair (
    .clk_i, .rst_ni,
    .valid_i(chip_valid_i), .pos_i(chip_pos), .re_i(s0_re), .im_i(s0_im),
    .valid_o(s1_valid), .pos_o(s1_pos), .re_o(s1_re), .im_o(s1_im)
  );

  cck_bfly_stage #(.IN_W(W1), .N_IN(4)) u_quad (
    .clk_i, .rst_ni,
    .valid_i(s1_valid), .pos_i(s1_pos), .re_i(s1_re), .im_i(s1_im),
    .valid_o(s2_valid), .pos_o(s2_pos), .re_o(s2_re), .im_o(s2_im)
  );

  cck_bfly_stage #(.IN_W(W2), .N_IN(16)) u_word (
    .clk_i, .rst_ni,
    .valid_i(s2_valid), .pos_i(s2_pos), .re_i(s2_re), .im_i(s2_im),
    .valid_o(s3_valid), .pos_o(s3_pos), .re_o(s3_re), .im_o(s3_im)
  );

  cck_peak_pick #(.W(W3), .N(NUM_HYP), .IDX_W(IDX_W)) u_peak (
    .clk_i, .rst_ni,
    .valid_i(s3_valid && (s3_pos == '0)),
    .re_i(s3_re), .im_i(s3_im),
    .valid_o(result_valid_o), .idx_o(result_idx_o), .mag_o(result_mag_o)
  );
endmodule

// File: rtl/cck_correlator_chk.sv
module cck_correlator_chk #(
  parameter int unsigned CHIP_W = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      chip_valid_i,
  input logic                      result_valid_o,
  input logic [cck_pkg::IDX_W-1:0] result_idx_o,
  input logic [CHIP_W+4:0]         result_mag_o
);
  localparam int unsigned MAG_LIMIT = 2 * cck_pkg::CHIPS_PER_WORD * (2 ** (CHIP_W - 1));

  logic [cck_pkg::POS_W-1:0] cnt;
  logic [2:0]                done_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt     <= '0;
      done_sr <= '0;
    end else begin
      if (chip_valid_i) cnt <= cnt + 1'b1;
      done_sr <= {done_sr[1:0], chip_valid_i && (cnt == '1)};
    end
  end

  a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_sr[2] |=> result_valid_o);

  a_r6_no_stray: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> $past(done_sr[2]));

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  a_r8_mag_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> (result_mag_o <= (CHIP_W+5)'(MAG_LIMIT)));

  a_r3_idx_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> !$isunknown({result_idx_o, result_mag_o}));
endmodule

bind cck_correlator cck_correlator_chk #(.CHIP_W(CHIP_W)) u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .chip_valid_i(chip_valid_i),
  .result_valid_o(result_valid_o),
  .result_idx_o(result_idx_o),
  .result_mag_o(result_mag_o)
);

// File: tb/cck_correlator_bench.sv
`timescale 1ns/1ps
module cck_correlator_bench;
  localparam int unsigned CHIP_W = 8;
  localparam longint WATCHDOG_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_valid = 1'b0;
  logic signed [CHIP_W-1:0] chip_re = '0;
  logic signed [CHIP_W-1:0] chip_im = '0;
  logic result_valid;
  logic [5:0] result_idx;
  logic [CHIP_W+4:0] result_mag;

  always #2 clk = ~clk;

  cck_correlator #(.CHIP_W(CHIP_W)) u_cck_correlator (
    .clk_i(clk), .rst_ni(rst_n), .chip_valid_i(chip_valid),
    .chip_re_i(chip_re), .chip_im_i(chip_im),
    .result_valid_o(result_valid), .result_idx_o(result_idx), .result_mag_o(result_mag)
  );

  typedef struct { int idx; int mag; longint due; string tag; } exp_t;
  exp_t   sb[$];
  int     n_cmp = 0;
  int     n_bad = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // direct form of the R2 sum over all hypotheses, R4 magnitude, R5 tie rule
  function automatic void model(input int re[8], input int im[8], output int bidx, output int bmag);
    bmag = -1;
    bidx = 0;
    for (int h = 0; h < 64; h++) begin
      int d2, d3, d4, zr, zi, m;
      d2 = h & 3; d3 = (h >> 2) & 3; d4 = (h >> 4) & 3;
      zr = 0; zi = 0;
      for (int k = 0; k < 8; k++) begin
        int e, s, xr, xi;
        e = (((k & 1) != 0) ? 0 : d2) + (((k & 2) != 0) ? 0 : d3) + (((k & 4) != 0) ? 0 : d4);
        e = e % 4;
        s = (k == 3 || k == 6) ? -1 : 1;
        xr = s * re[k]; xi = s * im[k];
        case (e)
          0: begin zr += xr; zi += xi; end
          1: begin zr += xi; zi -= xr; end
          2: begin zr -= xr; zi -= xi; end
          default: begin zr -= xi; zi += xr; end
        endcase
      end
      m = (zr < 0 ? -zr : zr) + (zi < 0 ? -zi : zi);
      if (m > bmag) begin bmag = m; bidx = h; end
    end
  endfunction

  function automatic void make_word(input int p1, input int p2, input int p3, input int p4,
                                    input int amp, output int re[8], output int im[8]);
    for (int k = 0; k < 8; k++) begin
      int e, s;
      e = p1 + (((k & 1) != 0) ? 0 : p2) + (((k & 2) != 0) ? 0 : p3) + (((k & 4) != 0) ? 0 : p4);
      s = (k == 3 || k == 6) ? -1 : 1;
      case (e % 4)
        0: begin re[k] = s * amp; im[k] = 0; end
        1: begin re[k] = 0; im[k] = s * amp; end
        2: begin re[k] = -s * amp; im[k] = 0; end
        default: begin re[k] = 0; im[k] = -s * amp; end
      endcase
    end
  endfunction

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      chip_valid = 1'b0;
    end
  endtask

  task automatic send_word(input int re[8], input int im[8], input int gap, input string tag);
    int bi, bm;
    model(re, im, bi, bm);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) idle(gap);
      @(negedge clk);
      chip_valid = 1'b1;
      chip_re = CHIP_W'(re[k]);
      chip_im = CHIP_W'(im[k]);
      if (k == 7) sb.push_back('{bi, bm, cyc + 4, tag});
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && result_valid && !done) begin
      if (sb.size() == 0) begin
        check("R6", "unexpected result strobe", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "result cycle", cyc, e.due);
        check(e.tag, "index", result_idx, e.idx);
        check(e.tag, "magnitude", result_mag, e.mag);
      end
    end
  end

  initial begin
    #(WATCHDOG_CYC * 4);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int re[8], im[8];
    int unsigned lcg;
    lcg = 32'h1234_5678;

    idle(3);
    check("R9", "valid in reset", result_valid, 0);
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    check("R9", "valid after reset", result_valid, 0);
    check("R9", "index after reset", result_idx, 0);
    check("R9", "magnitude after reset", result_mag, 0);

    // R2/R3: clean codewords, back to back (R7)
    make_word(0, 0, 0, 0, 100, re, im); send_word(re, im, 0, "R2");
    make_word(1, 2, 3, 1, 127, re, im); send_word(re, im, 0, "R7");
    make_word(3, 3, 3, 3, 50, re, im);  send_word(re, im, 0, "R3");
    make_word(2, 1, 0, 3, 127, re, im); send_word(re, im, 0, "R7");
    idle(6);

    // R1: idle gaps between chips
    make_word(1, 3, 0, 2, 90, re, im);  send_word(re, im, 2, "R1");
    make_word(0, 1, 2, 0, 60, re, im);  send_word(re, im, 5, "R1");
    idle(6);

    // R5: ties
    for (int k = 0; k < 8; k++) begin re[k] = 0; im[k] = 0; end
    send_word(re, im, 0, "R5");
    re[7] = 50;
    send_word(re, im, 0, "R5");
    re[7] = 0; re[0] = -70; im[0] = 30;
    send_word(re, im, 1, "R5");
    idle(6);

    // R8: full scale
    for (int k = 0; k < 8; k++) begin re[k] = -128; im[k] = -128; end
    send_word(re, im, 0, "R8");
    for (int k = 0; k < 8; k++) begin re[k] = (k % 2) ? 127 : -128; im[k] = (k % 3) ? -128 : 127; end
    send_word(re, im, 0, "R8");
    for (int k = 0; k < 8; k++) begin
      int s;
      s = (k == 3 || k == 6) ? 128 : -128;
      re[k] = (s > 127) ? 127 : s; im[k] = -128;
    end
    send_word(re, im, 0, "R8");
    idle(6);

    // R4: pseudo-random words
    for (int w = 0; w < 12; w++) begin
      for (int k = 0; k < 8; k++) begin
        lcg = lcg * 32'd1103515245 + 32'd12345;
        re[k] = int'((lcg >> 16) & 32'hFF) - 128;
        lcg = lcg * 32'd1103515245 + 32'd12345;
        im[k] = int'((lcg >> 16) & 32'hFF) - 128;
      end
      send_word(re, im, w % 3, "R4");
    end
    idle(8);

    // R9: reset in the middle of a word drops the partial word
    make_word(2, 2, 1, 1, 80, re, im);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chip_valid = 1'b1; chip_re = CHIP_W'(re[k]); chip_im = CHIP_W'(im[k]);
    end
    @(negedge clk);
    chip_valid = 1'b0;
    rst_n = 1'b0;
    idle(2);
    check("R9", "valid during mid-word reset", result_valid, 0);
    check("R9", "index during mid-word reset", result_idx, 0);
    @(negedge clk) rst_n = 1'b1;
    make_word(3, 0, 2, 1, 110, re, im); send_word(re, im, 0, "R9");
    idle(10);

    check("R6", "results still outstanding", sb.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule